// File: doc/BRIEF.md
# Programmable Cross-Trigger Unit

This block links eight trigger inputs to eight trigger outputs through a layer of four event channels. Software sets, for each trigger input, the channels it raises. For each trigger output it sets the channels that fire it. With this, one event can reach one or many outputs, and several events can share one output.

The channels also face a shared matrix. Events that this unit puts on a channel are offered on a channel output port, so that other units can receive them. Events that other units raise arrive on a channel input port and fire local outputs exactly as local events do.

A small register bus configures the unit. It has a select, a write strobe, an address and write data. Read data is combinational while the select is high with the write strobe low, and is zero at all other times. A software register can inject a channel event that lasts one cycle. Two status words show the sampled input levels and the last active channel vector.

Top module: `xtrig_unit`

## Requirements
- R1: After reset, the enable bit is clear and every channel mask reads zero. Both `trig_out` and `chan_out` are zero.
- R2: Input k has a 4-bit channel mask at byte offset 0x20+4k. Output k has a 4-bit channel mask at byte offset 0xA0+4k. Each mask is written from wdata[3:0], and it reads back in rdata[3:0] with the upper bits zero.
- R3: The enable bit is bit 0 of the control word at offset 0x00. While it is clear, `chan_out` stays zero and no `trig_out` bit asserts, whatever `trig_in` and `chan_in` carry.
- R4: `trig_in` is registered on each rising edge. In the cycle after that edge, `chan_out` shows the OR of the masks of the inputs sampled high, ORed with the software pulse bits.
- R5: The active vector is `chan_out` ORed with `chan_in`. An output fires when the active vector overlaps its mask. On the first cycle of such an overlap, the output gives a pulse one cycle long in the following cycle. It does not pulse again until the overlap has ended.
- R6: A bit on `chan_in` fires every output whose mask holds that channel. It is never echoed on `chan_out`.
- R7: A write to offset 0x1C makes the channels in wdata[3:0] active for exactly one cycle, the cycle after the write. That word reads as zero.
- R8: Offset 0x130 reads the registered `trig_in` levels in rdata[7:0]. Offset 0x134 reads the active vector of the previous cycle in rdata[3:0].
- R9: Any other offset, including one that is not word aligned, reads as zero. A write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (read when low) |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| trig_in | input | 8 | Trigger event inputs |
| trig_out | output | 8 | Trigger output pulses |
| chan_in | input | 4 | Channel events from the matrix |
| chan_out | output | 4 | Channel events offered to the matrix |

## Verification
Three sources can land on one channel in the same cycle: a rising trigger input, a matrix event on `chan_in`, and a software pulse. The bench writes the pulse register on the same edge that samples a new input level, and it raises the matching `chan_in` bit one cycle later. This puts all three on channel 3 in one cycle. The bench then expects exactly one pulse on each output mapped to that channel. A behavioural model is compared with `trig_out` and `chan_out` on every clock, so an extra pulse or a shifted one is caught at the cycle where it appears.

// File: rtl/xtrig_pkg.sv
`timescale 1ns/1ps
package xtrig_pkg;
  localparam int unsigned OFS_CTRL     = 32'h000;
  localparam int unsigned OFS_SWPULSE  = 32'h01C;
  localparam int unsigned OFS_INMAP    = 32'h020;
  localparam int unsigned OFS_OUTMAP   = 32'h0A0;
  localparam int unsigned OFS_TRIGSTAT = 32'h130;
  localparam int unsigned OFS_CHANSTAT = 32'h134;

  typedef enum logic [2:0] {
    XT_NONE,
    XT_CTRL,
    XT_SWPULSE,
    XT_INMAP,
    XT_OUTMAP,
    XT_TRIGSTAT,
    XT_CHANSTAT
  } xt_reg_e;
endpackage

// File: rtl/xtrig_regs.sv
`timescale 1ns/1ps
module xtrig_regs
  import xtrig_pkg::*;
#(
  parameter int unsigned N_TRIG = 8,
  parameter int unsigned N_CHAN = 4,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_sel,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  input  logic [N_TRIG-1:0]              trig_lvl,
  input  logic [N_CHAN-1:0]              chan_last,
  output logic                           en,
  output logic [N_CHAN-1:0]              sw_pulse,
  output logic [N_TRIG-1:0][N_CHAN-1:0]  in_map,
  output logic [N_TRIG-1:0][N_CHAN-1:0]  out_map,
  output logic [DATA_W-1:0]              bus_rdata
);
  localparam int unsigned IDX_W = (N_TRIG > 1) ? $clog2(N_TRIG) : 1;
  localparam logic [ADDR_W-1:0] A_CTRL     = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_SWPULSE  = ADDR_W'(OFS_SWPULSE);
  localparam logic [ADDR_W-1:0] A_IN_LO    = ADDR_W'(OFS_INMAP);
  localparam logic [ADDR_W-1:0] A_IN_HI    = ADDR_W'(OFS_INMAP + 4 * N_TRIG);
  localparam logic [ADDR_W-1:0] A_OUT_LO   = ADDR_W'(OFS_OUTMAP);
  localparam logic [ADDR_W-1:0] A_OUT_HI   = ADDR_W'(OFS_OUTMAP + 4 * N_TRIG);
  localparam logic [ADDR_W-1:0] A_TRIGSTAT = ADDR_W'(OFS_TRIGSTAT);
  localparam logic [ADDR_W-1:0] A_CHANSTAT = ADDR_W'(OFS_CHANSTAT);

  xt_reg_e                          kind;
  logic [IDX_W-1:0]                 idx;
  logic                             wr_en;
  logic                             cfg_ce;
  logic                             en_q, en_d;
  logic [N_CHAN-1:0]                pulse_q, pulse_d;
  logic [N_TRIG-1:0][N_CHAN-1:0]    imap_q, imap_d;
  logic [N_TRIG-1:0][N_CHAN-1:0]    omap_q, omap_d;
  logic                             unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:N_CHAN];

  // address decode
  always_comb begin
    kind = XT_NONE;
    idx  = '0;
    if (bus_addr[1:0] == 2'b00) begin
      if (bus_addr == A_CTRL) begin
        kind = XT_CTRL;
      end else if (bus_addr == A_SWPULSE) begin
        kind = XT_SWPULSE;
      end else if (bus_addr >= A_IN_LO && bus_addr < A_IN_HI) begin
        kind = XT_INMAP;
        idx  = IDX_W'((bus_addr - A_IN_LO) >> 2);
      end else if (bus_addr >= A_OUT_LO && bus_addr < A_OUT_HI) begin
        kind = XT_OUTMAP;
        idx  = IDX_W'((bus_addr - A_OUT_LO) >> 2);
      end else if (bus_addr == A_TRIGSTAT) begin
        kind = XT_TRIGSTAT;
      end else if (bus_addr == A_CHANSTAT) begin
        kind = XT_CHANSTAT;
      end
    end
  end

  assign wr_en  = bus_sel & bus_wr;
  assign cfg_ce = wr_en & ((kind == XT_CTRL) | (kind == XT_INMAP) | (kind == XT_OUTMAP));

  // next state
  always_comb begin
    en_d    = en_q;
    imap_d  = imap_q;
    omap_d  = omap_q;
    pulse_d = '0;
    if (wr_en) begin
      case (kind)
        XT_CTRL:    en_d         = bus_wdata[0];
        XT_SWPULSE: pulse_d      = bus_wdata[N_CHAN-1:0];
        XT_INMAP:   imap_d[idx]  = bus_wdata[N_CHAN-1:0];
        XT_OUTMAP:  omap_d[idx]  = bus_wdata[N_CHAN-1:0];
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      imap_q  <= '0;
      omap_q  <= '0;
      pulse_q <= '0;
    end else begin
      if (cfg_ce) begin
        en_q   <= en_d;
        imap_q <= imap_d;
        omap_q <= omap_d;
      end
      pulse_q <= pulse_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (kind)
        XT_CTRL:     bus_rdata[0]          = en_q;
        XT_INMAP:    bus_rdata[N_CHAN-1:0] = imap_q[idx];
        XT_OUTMAP:   bus_rdata[N_CHAN-1:0] = omap_q[idx];
        XT_TRIGSTAT: bus_rdata[N_TRIG-1:0] = trig_lvl;
        XT_CHANSTAT: bus_rdata[N_CHAN-1:0] = chan_last;
        default: ;
      endcase
    end
  end

  assign en       = en_q;
  assign sw_pulse = pulse_q;
  assign in_map   = imap_q;
  assign out_map  = omap_q;
endmodule

// File: rtl/xtrig_route.sv
`timescale 1ns/1ps
module xtrig_route #(
  parameter int unsigned N_TRIG = 8,
  parameter int unsigned N_CHAN = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           en,
  input  logic [N_TRIG-1:0]              trig_in,
  input  logic [N_CHAN-1:0]              chan_in,
  input  logic [N_CHAN-1:0]              sw_pulse,
  input  logic [N_TRIG-1:0][N_CHAN-1:0]  in_map,
  input  logic [N_TRIG-1:0][N_CHAN-1:0]  out_map,
  output logic [N_TRIG-1:0]              trig_lvl,
  output logic [N_CHAN-1:0]              chan_drive,
  output logic [N_CHAN-1:0]              chan_last,
  output logic [N_TRIG-1:0]              hit
);
  logic [N_TRIG-1:0] trig_q, trig_d;
  logic [N_CHAN-1:0] clast_q, clast_d;
  logic [N_CHAN-1:0] src;
  logic [N_CHAN-1:0] active;

  // channels raised by this unit
  always_comb begin
    src = sw_pulse;
    for (int k = 0; k < N_TRIG; k++) begin
      if (trig_q[k]) src = src | in_map[k];
    end
  end

  assign chan_drive = en ? src : '0;
  assign active     = en ? (src | chan_in) : '0;

  genvar j;
  generate
    for (j = 0; j < N_TRIG; j++) begin : g_hit
      assign hit[j] = |(active & out_map[j]);
    end
  endgenerate

  assign trig_d  = trig_in;
  assign clast_d = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q  <= '0;
      clast_q <= '0;
    end else begin
      trig_q  <= trig_d;
      clast_q <= clast_d;
    end
  end

  assign trig_lvl  = trig_q;
  assign chan_last = clast_q;
endmodule

// File: rtl/xtrig_pulse.sv
`timescale 1ns/1ps
module xtrig_pulse #(
  parameter int unsigned N_TRIG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TRIG-1:0] hit,
  output logic [N_TRIG-1:0] pulse_out
);
  genvar j;
  generate
    for (j = 0; j < N_TRIG; j++) begin : g_out
      logic hit_q;
      logic out_q, out_d;

      assign out_d = hit[j] & ~hit_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hit_q <= 1'b0;
          out_q <= 1'b0;
        end else begin
          hit_q <= hit[j];
          out_q <= out_d;
        end
      end

      assign pulse_out[j] = out_q;
    end
  endgenerate
endmodule

// File: rtl/xtrig_unit.sv
`timescale 1ns/1ps
module xtrig_unit #(
  parameter int unsigned N_TRIG = 8,
  parameter int unsigned N_CHAN = 4,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_TRIG-1:0] trig_in,
  output logic [N_TRIG-1:0] trig_out,
  input  logic [N_CHAN-1:0] chan_in,
  output logic [N_CHAN-1:0] chan_out
);
  logic                           en_q;
  logic [N_CHAN-1:0]              sw_pulse;
  logic [N_TRIG-1:0][N_CHAN-1:0]  in_map;
  logic [N_TRIG-1:0][N_CHAN-1:0]  out_map;
  logic [N_TRIG-1:0]              trig_lvl;
  logic [N_CHAN-1:0]              chan_last;
  logic [N_TRIG-1:0]              hit;

  xtrig_regs #(
    .N_TRIG(N_TRIG), .N_CHAN(N_CHAN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .trig_lvl  (trig_lvl),
    .chan_last (chan_last),
    .en        (en_q),
    .sw_pulse  (sw_pulse),
    .in_map    (in_map),
    .out_map   (out_map),
    .bus_rdata (bus_rdata)
  );

  xtrig_route #(
    .N_TRIG(N_TRIG), .N_CHAN(N_CHAN)
  ) u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en_q),
    .trig_in    (trig_in),
    .chan_in    (chan_in),
    .sw_pulse   (sw_pulse),
    .in_map     (in_map),
    .out_map    (out_map),
    .trig_lvl   (trig_lvl),
    .chan_drive (chan_out),
    .chan_last  (chan_last),
    .hit        (hit)
  );

  xtrig_pulse #(
    .N_TRIG(N_TRIG)
  ) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .pulse_out (trig_out)
  );
endmodule

// File: rtl/xtrig_unit_chk.sv
`timescale 1ns/1ps
module xtrig_unit_chk
  import xtrig_pkg::*;
#(
  parameter int unsigned N_TRIG = 8,
  parameter int unsigned N_CHAN = 4,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [N_TRIG-1:0] trig_out,
  input logic [N_CHAN-1:0] chan_in,
  input logic [N_CHAN-1:0] chan_out
);
  localparam logic [ADDR_W-1:0] C_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] C_PULSE = ADDR_W'(OFS_SWPULSE);
  localparam logic [ADDR_W-1:0] C_IN0   = ADDR_W'(OFS_INMAP);
  localparam logic [ADDR_W-1:0] C_INE   = ADDR_W'(OFS_INMAP + 4 * N_TRIG);
  localparam logic [ADDR_W-1:0] C_OUT0  = ADDR_W'(OFS_OUTMAP);
  localparam logic [ADDR_W-1:0] C_OUTE  = ADDR_W'(OFS_OUTMAP + 4 * N_TRIG);
  localparam logic [ADDR_W-1:0] C_TST   = ADDR_W'(OFS_TRIGSTAT);
  localparam logic [ADDR_W-1:0] C_CST   = ADDR_W'(OFS_CHANSTAT);

  logic is_mapped;
  logic unused_hi;

  assign unused_hi = ^bus_wdata[DATA_W-1:N_CHAN];

  always_comb begin
    is_mapped = 1'b0;
    if (bus_addr[1:0] == 2'b00) begin
      is_mapped = (bus_addr == C_CTRL) || (bus_addr == C_PULSE) ||
                  (bus_addr == C_TST)  || (bus_addr == C_CST)   ||
                  (bus_addr >= C_IN0 && bus_addr < C_INE)       ||
                  (bus_addr >= C_OUT0 && bus_addr < C_OUTE);
    end
  end

  // R3: a cleared enable keeps every output low in the cycle after
  p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (trig_out == '0));

  // R5: an output pulse never lasts two cycles
  p_single_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((trig_out & $past(trig_out)) == '0));

  // R5: an output pulse needs a channel active in the cycle before
  p_pulse_has_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out != '0) |-> ($past(chan_out | chan_in) != '0));

  // R7: software pulse bits appear on the matrix port one cycle after the write
  p_sw_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == C_PULSE && en) |=>
      ((chan_out & $past(bus_wdata[N_CHAN-1:0])) == $past(bus_wdata[N_CHAN-1:0])));

  // R9: unmapped offsets read as zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !is_mapped) |-> (bus_rdata == '0));
endmodule

bind xtrig_unit xtrig_unit_chk #(
  .N_TRIG(N_TRIG), .N_CHAN(N_CHAN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en_q),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .trig_out  (trig_out),
  .chan_in   (chan_in),
  .chan_out  (chan_out)
);

// File: tb/xtrig_unit_bench.sv
`timescale 1ns/1ps
module xtrig_unit_bench;
  logic        clk;
  logic        rst_n;
  logic        sel, wr_r;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [7:0]  trig_in, trig_out;
  logic [3:0]  chan_in, chan_out;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  xtrig_unit u_xtrig_unit (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr_r), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .trig_in(trig_in), .trig_out(trig_out),
    .chan_in(chan_in), .chan_out(chan_out)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // behavioural reference model
  logic [3:0] m_imap [8];
  logic [3:0] m_omap [8];
  logic       m_en;
  logic [7:0] m_trq, m_hitq, m_tout;
  logic [3:0] m_pulse, m_clast;
  logic [3:0] act_v;
  logic [7:0] hit_v;

  function automatic logic [3:0] m_local();
    logic [3:0] s;
    s = m_pulse;
    for (int k = 0; k < 8; k++) if (m_trq[k]) s = s | m_imap[k];
    return m_en ? s : 4'h0;
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    if (a == 12'h000) return {31'h0, m_en};
    if (a >= 12'h020 && a <= 12'h03C) return {28'h0, m_imap[int'((a - 12'h020) >> 2)]};
    if (a >= 12'h0A0 && a <= 12'h0BC) return {28'h0, m_omap[int'((a - 12'h0A0) >> 2)]};
    if (a == 12'h130) return {24'h0, m_trq};
    if (a == 12'h134) return {28'h0, m_clast};
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_trq = 0; m_hitq = 0; m_tout = 0; m_pulse = 0; m_clast = 0;
      for (int k = 0; k < 8; k++) begin m_imap[k] = 0; m_omap[k] = 0; end
    end else begin
      act_v = m_en ? (m_local() | chan_in) : 4'h0;
      for (int j = 0; j < 8; j++) hit_v[j] = |(act_v & m_omap[j]);
      m_tout  = hit_v & ~m_hitq;
      m_hitq  = hit_v;
      m_clast = act_v;
      m_trq   = trig_in;
      m_pulse = 0;
      if (sel && wr_r && addr[1:0] == 2'b00) begin
        if (addr == 12'h000) m_en = wdata[0];
        else if (addr == 12'h01C) m_pulse = wdata[3:0];
        else if (addr >= 12'h020 && addr <= 12'h03C) m_imap[int'((addr - 12'h020) >> 2)] = wdata[3:0];
        else if (addr >= 12'h0A0 && addr <= 12'h0BC) m_omap[int'((addr - 12'h0A0) >> 2)] = wdata[3:0];
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-clock comparison and observation counters
  int pcnt [8];
  int ch1_hi;
  logic [3:0] chan_acc;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R5 trig_out vs model", {24'h0, trig_out}, {24'h0, m_tout});
      check("R4 chan_out vs model", {28'h0, chan_out}, {28'h0, m_local()});
      for (int j = 0; j < 8; j++) pcnt[j] += int'(trig_out[j]);
      ch1_hi += int'(chan_out[1]);
      chan_acc = chan_acc | chan_out;
    end
  end

  task automatic clr();
    for (int j = 0; j < 8; j++) pcnt[j] = 0;
    ch1_hi = 0;
    chan_acc = 0;
  endtask

  function automatic int ptotal();
    int s = 0;
    for (int j = 0; j < 8; j++) s += pcnt[j];
    return s;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1; wr_r = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; wr_r = 0;
  endtask

  task automatic brd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    sel = 1; wr_r = 0; addr = a;
    #1;
    check(tag, rdata, exp);
    sel = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; sel = 0; wr_r = 0; addr = 0; wdata = 0; trig_in = 0; chan_in = 0;
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check("R1 trig_out at reset", {24'h0, trig_out}, 32'h0);
    check("R1 chan_out at reset", {28'h0, chan_out}, 32'h0);
    brd(12'h000, 32'h0, "R1 ctrl");
    brd(12'h020, 32'h0, "R1 in map 0");
    brd(12'h0BC, 32'h0, "R1 out map 7");

    // R2 mask storage
    bwr(12'h024, 32'hFFFF_FFF5);
    brd(12'h024, 32'h5, "R2 in map 1");
    bwr(12'h0BC, 32'h9);
    brd(12'h0BC, 32'h9, "R2 out map 7");
    bwr(12'h024, 0);
    bwr(12'h0BC, 0);

    // R5 one-to-many: in0 -> ch3 -> out3, out7
    bwr(12'h000, 1);
    bwr(12'h020, 32'h8);
    bwr(12'h0AC, 32'h8);
    bwr(12'h0BC, 32'h8);
    clr();
    @(negedge clk); trig_in = 8'h01;
    idle(5); trig_in = 0; idle(4);
    check("R5 one-to-many out3", pcnt[3], 1);
    check("R5 one-to-many out7", pcnt[7], 1);
    check("R5 one-to-many total", ptotal(), 2);

    // R5 many-to-one: in1 -> ch0, in2 -> ch1, out0 on ch0|ch1
    bwr(12'h024, 32'h1);
    bwr(12'h028, 32'h2);
    bwr(12'h0A0, 32'h3);
    clr();
    @(negedge clk); trig_in = 8'h02;
    idle(3); trig_in = 8'h06;
    idle(3); trig_in = 0;
    idle(3); trig_in = 8'h04;
    idle(3); trig_in = 0; idle(3);
    check("R5 many-to-one out0", pcnt[0], 2);
    check("R5 many-to-one out3 idle", pcnt[3], 0);

    // R6 matrix input fires outputs, not echoed
    bwr(12'h0B4, 32'h4);
    clr();
    @(negedge clk); chan_in = 4'h4;
    idle(4); chan_in = 0; idle(3);
    check("R6 out5 from matrix", pcnt[5], 1);
    check("R6 no echo on chan_out", {28'h0, chan_acc}, 32'h0);

    // R7 software pulse
    bwr(12'h0B8, 32'h2);
    clr();
    bwr(12'h01C, 32'h2);
    idle(4);
    check("R7 ch1 high cycles", ch1_hi, 1);
    check("R7 out6 pulses", pcnt[6], 1);
    check("R7 out0 pulses", pcnt[0], 1);
    brd(12'h01C, 32'h0, "R7 pulse word reads zero");

    // R5 same-cycle input, matrix and software pulse on ch3
    clr();
    @(negedge clk);
    sel = 1; wr_r = 1; addr = 12'h01C; wdata = 32'h8; trig_in = 8'h01;
    @(negedge clk);
    sel = 0; wr_r = 0; chan_in = 4'h8;
    idle(3); trig_in = 0; chan_in = 0; idle(3);
    check("R5 coincident out3", pcnt[3], 1);
    check("R5 coincident out7", pcnt[7], 1);

    // R3 disabled
    bwr(12'h000, 0);
    clr();
    @(negedge clk); trig_in = 8'hFF; chan_in = 4'hF;
    idle(5);
    check("R3 no pulses when off", ptotal(), 0);
    check("R3 chan_out quiet when off", {28'h0, chan_acc}, 32'h0);
    brd(12'h000, 32'h0, "R3 ctrl reads clear");
    brd(12'h130, 32'hFF, "R8 levels while off");
    brd(12'h134, 32'h0, "R8 chan status while off");
    trig_in = 0; chan_in = 0; idle(2);

    // R8 status words
    bwr(12'h000, 1);
    @(negedge clk); trig_in = 8'h05;
    idle(3);
    brd(12'h130, 32'h05, "R8 trig levels");
    brd(12'h134, 32'hA, "R8 last channels");
    trig_in = 0; idle(3);

    // R9 unmapped offsets
    bwr(12'h040, 32'hFFFF_FFFF);
    bwr(12'h100, 32'hFFFF_FFFF);
    bwr(12'h022, 32'hFFFF_FFFF);
    bwr(12'h0C0, 32'hFFFF_FFFF);
    bwr(12'h1FC, 32'hFFFF_FFFF);
    brd(12'h040, 32'h0, "R9 read 0x040");
    brd(12'h100, 32'h0, "R9 read 0x100");
    brd(12'h022, 32'h0, "R9 read 0x022");
    brd(12'h1FC, 32'h0, "R9 read 0x1FC");
    for (int k = 0; k < 8; k++) begin
      brd(12'(12'h020 + 4 * k), m_read(12'(12'h020 + 4 * k)), "R9 in map unchanged");
      brd(12'(12'h0A0 + 4 * k), m_read(12'(12'h0A0 + 4 * k)), "R9 out map unchanged");
    end
    check("R9 in map 0 still ch3", {28'h0, m_imap[0]}, 32'h8);
    brd(12'h000, 32'h1, "R9 ctrl unchanged");
    idle(2);

    done = 1;
    summary();
    $finish;
  end
endmodule